// File: doc/BRIEF.md
# Two-Address Paged Register Decoder

This block sits behind a byte-level two-wire slave front end and turns each transaction into accesses on a physical memory port. The front end reports four kinds of event: a start with the device byte, a stop, a received write byte, and a request for the next read byte. The decoder does three things with them. It decides whether the device byte addresses this block. It holds the byte pointer. It maps every byte access onto one of three regions: the main register file, a numbered table page, or a 128-byte auxiliary memory. The bit-level line protocol and the nonvolatile write timing belong to other blocks.

The byte space of the main device has two halves. The lower half is flat, and location 7Fh holds an internal page register. The page register chooses what appears in the upper half. Two operating modes exist. In dual-address mode a second device address reaches the auxiliary memory directly. In single-address mode that second address gets no acknowledge, and page numbers 00h and 01h both open the auxiliary memory in the upper half. A fix input replaces the built-in main address with a programmable byte supplied from outside.

The control FSM has four states. ST_IDLE is entered at reset and on stop, and on a start that does not match. ST_PTR is entered from any state on a matching start with a write direction. It moves to ST_WR when the pointer byte arrives. ST_WR stays in place for each data byte and advances the pointer. ST_RD is entered from any state on a matching start with a read direction, and each read request advances the pointer. A start acts in every state and takes priority over stop, and stop takes priority over byte events.

Top module: `paged_reg_decoder`

## Requirements
- R1: The main device answers the 7-bit address 51h (device byte A2h/A3h) while cfg_fix_i is 0. While cfg_fix_i is 1 it answers cfg_main_addr_i[7:1] instead. ack_o pulses high for one cycle in the cycle after a start that matches.
- R2: The auxiliary address 50h (device byte A0h/A1h) is acknowledged only while cfg_single_i is 0. In single-address mode that start gets no ack_o, and the write bytes that follow it produce no memory request.
- R3: Through the main address, pointers 00h to 7Eh access region MAIN (mem_sel_o = 1) at mem_addr_o = pointer[6:0], whatever the page register holds.
- R4: Pointer 7Fh on the main address reads and writes the page register and raises no memory request. The page register resets to 00h.
- R5: Through the main address, a pointer of 80h or above with a page value from 2 to NUM_TABLES-1 (3 by default) accesses region TABLE (mem_sel_o = 2), with mem_tbl_o equal to the page value and mem_addr_o = pointer[6:0].
- R6: In single-address mode, page values 00h and 01h both map the upper half onto region AUX (mem_sel_o = 3) at mem_addr_o = pointer[6:0].
- R7: An upper-half access with an undefined page value reads FFh and raises no memory request. A page value is undefined when it is at or above NUM_TABLES, or when it is 00h or 01h in dual-address mode.
- R8: Every access through the auxiliary address goes to region AUX at mem_addr_o = pointer modulo 128. The auxiliary address never reaches the page register or the tables.
- R9: The pointer advances by one after each data byte or read byte and wraps from FFh to 00h. It keeps its value across transactions, so a read that follows a pointer write starts at that pointer.
- R10: After reset, ack_o and mem_req_o are low.
- R11: A start with any other device address leaves the block idle. Bytes that follow it raise no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_single_i | input | 1 | 1 selects single-address mode |
| cfg_fix_i | input | 1 | 1 takes the main address from cfg_main_addr_i |
| cfg_main_addr_i | input | 8 | Programmable main device byte (bits 7:1 used) |
| start_i | input | 1 | Start or repeated start, with dev_i valid |
| dev_i | input | 8 | Device byte; bit 0 is 1 for read |
| stop_i | input | 1 | Stop condition |
| wr_vld_i | input | 1 | A write byte is present on wr_byte_i |
| wr_byte_i | input | 8 | Received write byte |
| rd_req_i | input | 1 | Front end takes the next read byte |
| ack_o | output | 1 | Device address acknowledged (one-cycle pulse) |
| mem_req_o | output | 1 | Memory access in this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_sel_o | output | 2 | Region: 0 none, 1 main, 2 table, 3 aux |
| mem_tbl_o | output | 8 | Table number for region TABLE |
| mem_addr_o | output | 7 | Offset inside the region |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Memory read data, combinational to the address |
| rd_data_o | output | 8 | Byte handed to the front end on rd_req_i |

## Verification
The assertions take three things for granted. The front end raises at most one of start_i, stop_i, wr_vld_i and rd_req_i in any cycle. It raises wr_vld_i only in a write phase and rd_req_i only in a read phase. The configuration inputs change only while the block is idle. The bench drives every event as a single-cycle strobe with one strobe per cycle, and it changes the mode and fix inputs only between transactions. The memory returns data combinationally. The bench models it as a fixed function of region, table and offset, which lets each read show where it landed.

// File: rtl/paged_reg_pkg.sv
package paged_reg_pkg;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_MAIN  = 2'd1,
        SEL_TABLE = 2'd2,
        SEL_AUX   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/dev_match.sv
module dev_match #(
    parameter logic [6:0] MAIN_DEF = 7'h51,
    parameter logic [6:0] AUX_ADDR = 7'h50
) (
    input  logic [6:0] dev_addr_i,
    input  logic       single_i,
    input  logic       fix_i,
    input  logic [7:0] prog_byte_i,
    output logic       hit_main_o,
    output logic       hit_aux_o
);
    logic [6:0] main_addr;

    always_comb begin
        main_addr  = fix_i ? prog_byte_i[7:1] : MAIN_DEF;
        hit_main_o = (dev_addr_i == main_addr);
        hit_aux_o  = !single_i && (dev_addr_i == AUX_ADDR) && !hit_main_o;
    end
endmodule

// File: rtl/page_map.sv
module page_map
    import paged_reg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_TABLES = 4
) (
    input  logic              tgt_aux_i,
    input  logic              single_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] page_i,
    output region_e           sel_o,
    output logic [ADDR_W-1:0] tbl_o,
    output logic [ADDR_W-2:0] off_o,
    output logic              is_page_o,
    output logic              undef_o
);
    localparam int HALF_W = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] PAGE_LOC   = {1'b0, {HALF_W{1'b1}}};
    localparam logic [ADDR_W-1:0] FIRST_TBL  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] TBL_LIMIT  = ADDR_W'(NUM_TABLES);

    always_comb begin
        sel_o     = SEL_NONE;
        tbl_o     = page_i;
        off_o     = ptr_i[HALF_W-1:0];
        is_page_o = 1'b0;
        undef_o   = 1'b0;
        if (tgt_aux_i) begin
            sel_o = SEL_AUX;
        end else if (!ptr_i[ADDR_W-1]) begin
            if (ptr_i == PAGE_LOC) is_page_o = 1'b1;
            else                   sel_o     = SEL_MAIN;
        end else if (single_i && page_i < FIRST_TBL) begin
            sel_o = SEL_AUX;
        end else if (page_i >= FIRST_TBL && page_i < TBL_LIMIT) begin
            sel_o = SEL_TABLE;
        end else begin
            undef_o = 1'b1;
        end
    end
endmodule

// File: rtl/paged_reg_decoder.sv
module paged_reg_decoder
    import paged_reg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_TABLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_single_i,
    input  logic              cfg_fix_i,
    input  logic [7:0]        cfg_main_addr_i,
    input  logic              start_i,
    input  logic [7:0]        dev_i,
    input  logic              stop_i,
    input  logic              wr_vld_i,
    input  logic [7:0]        wr_byte_i,
    input  logic              rd_req_i,
    output logic              ack_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_sel_o,
    output logic [ADDR_W-1:0] mem_tbl_o,
    output logic [ADDR_W-2:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        rd_data_o
);
    localparam int HALF_W = ADDR_W - 1;
    localparam logic [7:0] FILL = 8'hFF;

    ctl_state_e        state_q;
    logic              tgt_aux_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] page_q;
    logic              ack_q;

    logic              hit_main, hit_aux;
    region_e           dsel;
    logic [ADDR_W-1:0] dtbl;
    logic [HALF_W-1:0] doff;
    logic              is_page, undef;

    dev_match u_match (
        .dev_addr_i  (dev_i[7:1]),
        .single_i    (cfg_single_i),
        .fix_i       (cfg_fix_i),
        .prog_byte_i (cfg_main_addr_i),
        .hit_main_o  (hit_main),
        .hit_aux_o   (hit_aux)
    );

    page_map #(.ADDR_W(ADDR_W), .NUM_TABLES(NUM_TABLES)) u_map (
        .tgt_aux_i (tgt_aux_q),
        .single_i  (cfg_single_i),
        .ptr_i     (ptr_q),
        .page_i    (page_q),
        .sel_o     (dsel),
        .tbl_o     (dtbl),
        .off_o     (doff),
        .is_page_o (is_page),
        .undef_o   (undef)
    );

    // State register, pointer, page register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tgt_aux_q <= 1'b0;
            ptr_q     <= '0;
            page_q    <= '0;
            ack_q     <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (start_i) begin
                if (hit_main || hit_aux) begin
                    ack_q     <= 1'b1;
                    tgt_aux_q <= hit_aux;
                    state_q   <= dev_i[0] ? ST_RD : ST_PTR;
                end else begin
                    state_q   <= ST_IDLE;
                end
            end else if (stop_i) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_PTR: begin
                        if (wr_vld_i) begin
                            ptr_q   <= wr_byte_i[ADDR_W-1:0];
                            state_q <= ST_WR;
                        end
                    end
                    ST_WR: begin
                        if (wr_vld_i) begin
                            if (is_page) page_q <= wr_byte_i[ADDR_W-1:0];
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    ST_RD: begin
                        if (rd_req_i) ptr_q <= ptr_q + 1'b1;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_sel_o   = dsel;
        mem_tbl_o   = dtbl;
        mem_addr_o  = doff;
        mem_wdata_o = wr_byte_i;
        rd_data_o   = is_page ? 8'(page_q) : (undef ? FILL : mem_rdata_i);
        ack_o       = ack_q;
        unique case (state_q)
            ST_IDLE, ST_PTR: ;
            ST_WR: begin
                mem_req_o = wr_vld_i && !start_i && !stop_i && (dsel != SEL_NONE);
                mem_we_o  = mem_req_o;
            end
            ST_RD: begin
                mem_req_o = rd_req_i && !start_i && !stop_i && (dsel != SEL_NONE);
            end
        endcase
    end

    // Assertions
    p_ack_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(start_i));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mem_req_o);

    p_req_has_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_sel_o != SEL_NONE));

    p_aux_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single_i && mem_req_o && mem_sel_o == SEL_AUX) |-> (ptr_q[ADDR_W-1] && page_q < 2));

    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_WR && wr_vld_i && ptr_q == 8'h7F && !tgt_aux_q)
        |=> $stable(page_q));

    p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && rd_req_i && !start_i && !stop_i)
        |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: tb/paged_reg_decoder_tb.sv
module paged_reg_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_single = 1'b0, cfg_fix = 1'b0;
    logic [7:0] cfg_main = 8'h00;
    logic       start = 1'b0, stop = 1'b0, wr_vld = 1'b0, rd_req = 1'b0;
    logic [7:0] dev = 8'h00, wr_byte = 8'h00;
    logic       ack, mem_req, mem_we;
    logic [1:0] mem_sel;
    logic [7:0] mem_tbl, mem_wdata, rd_data, mem_rdata;
    logic [6:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [1:0] s, input logic [7:0] t, input logic [6:0] a);
        return {s, 6'b0} ^ {1'b0, a} ^ t;
    endfunction

    assign mem_rdata = mem_model(mem_sel, mem_tbl, mem_addr);

    paged_reg_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_single_i(cfg_single), .cfg_fix_i(cfg_fix),
        .cfg_main_addr_i(cfg_main), .start_i(start), .dev_i(dev), .stop_i(stop),
        .wr_vld_i(wr_vld), .wr_byte_i(wr_byte), .rd_req_i(rd_req), .ack_o(ack),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_sel_o(mem_sel), .mem_tbl_o(mem_tbl),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .rd_data_o(rd_data)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic [7:0] d, output logic acked);
        @(negedge clk); start = 1'b1; dev = d;
        @(negedge clk); start = 1'b0; #1 acked = ack;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic req, output logic [1:0] s,
                         output logic [7:0] t, output logic [6:0] a);
        @(negedge clk); wr_vld = 1'b1; wr_byte = b;
        #1 req = mem_req && mem_we; s = mem_sel; t = mem_tbl; a = mem_addr;
        @(negedge clk); wr_vld = 1'b0;
    endtask

    task automatic rbyte(output logic [7:0] d, output logic req, output logic [1:0] s,
                         output logic [7:0] t, output logic [6:0] a);
        @(negedge clk); rd_req = 1'b1;
        #1 d = rd_data; req = mem_req && !mem_we; s = mem_sel; t = mem_tbl; a = mem_addr;
        @(negedge clk); rd_req = 1'b0;
    endtask

    // write pointer then one data byte
    task automatic wr_at(input logic [7:0] d, input logic [7:0] p, input logic [7:0] b,
                         output logic acked, output logic req, output logic [1:0] s,
                         output logic [7:0] t, output logic [6:0] a);
        do_start(d, acked);
        wbyte(p, req, s, t, a);
        wbyte(b, req, s, t, a);
        do_stop();
    endtask

    // set pointer then read one byte via repeated start
    task automatic rd_at(input logic [7:0] d, input logic [7:0] p, output logic [7:0] data,
                         output logic req, output logic [1:0] s, output logic [7:0] t,
                         output logic [6:0] a);
        logic k; logic r0; logic [1:0] s0; logic [7:0] t0; logic [6:0] a0;
        do_start(d, k);
        wbyte(p, r0, s0, t0, a0);
        do_start(d | 8'h01, k);
        rbyte(data, req, s, t, a);
        do_stop();
    endtask

    task automatic t_reset();
        #1;
        chk(ack == 1'b0, "R10 ack", 32'(ack), 0);
        chk(mem_req == 1'b0, "R10 req", 32'(mem_req), 0);
    endtask

    task automatic t_main_lower();
        logic k, r; logic [1:0] s; logic [7:0] t, d; logic [6:0] a;
        wr_at(8'hA2, 8'h10, 8'h55, k, r, s, t, a);
        chk(k, "R1 ack A2", 32'(k), 1);
        chk(r && s == 2'd1 && a == 7'h10, "R3 main write", {r, s, a}, {1'b1, 2'd1, 7'h10});
        rd_at(8'hA2, 8'h7F, d, r, s, t, a);
        chk(d == 8'h00 && !r, "R4 page reset", {r, d}, {1'b0, 8'h00});
    endtask

    task automatic t_tables();
        logic k, r; logic [1:0] s; logic [7:0] t, d; logic [6:0] a;
        wr_at(8'hA2, 8'h7F, 8'h03, k, r, s, t, a);
        chk(!r, "R4 page write no req", 32'(r), 0);
        rd_at(8'hA2, 8'h7F, d, r, s, t, a);
        chk(d == 8'h03 && !r, "R4 page read", {r, d}, {1'b0, 8'h03});
        wr_at(8'hA2, 8'h85, 8'h66, k, r, s, t, a);
        chk(r && s == 2'd2 && t == 8'h03 && a == 7'h05, "R5 table write",
            {r, s, t, a}, {1'b1, 2'd2, 8'h03, 7'h05});
        rd_at(8'hA2, 8'h20, d, r, s, t, a);
        chk(r && s == 2'd1 && a == 7'h20 && d == mem_model(2'd1, 8'h03, 7'h20), "R3 lower ignores page",
            {r, s, a, d}, {1'b1, 2'd1, 7'h20, mem_model(2'd1, 8'h03, 7'h20)});
    endtask

    task automatic t_undef();
        logic k, r; logic [1:0] s; logic [7:0] t, d; logic [6:0] a;
        wr_at(8'hA2, 8'h7F, 8'h09, k, r, s, t, a);
        rd_at(8'hA2, 8'h90, d, r, s, t, a);
        chk(d == 8'hFF && !r, "R7 undefined read", {r, d}, {1'b0, 8'hFF});
        wr_at(8'hA2, 8'h90, 8'h12, k, r, s, t, a);
        chk(!r, "R7 undefined write", 32'(r), 0);
        wr_at(8'hA2, 8'h7F, 8'h00, k, r, s, t, a);
        rd_at(8'hA2, 8'h8A, d, r, s, t, a);
        chk(d == 8'hFF && !r, "R7 page 0 dual mode", {r, d}, {1'b0, 8'hFF});
    endtask

    task automatic t_aux_dual();
        logic k, r; logic [1:0] s; logic [7:0] t, d; logic [6:0] a;
        wr_at(8'hA0, 8'hF3, 8'h77, k, r, s, t, a);
        chk(k, "R2 ack A0 dual", 32'(k), 1);
        chk(r && s == 2'd3 && a == 7'h73, "R8 aux wrap", {r, s, a}, {1'b1, 2'd3, 7'h73});
        wr_at(8'hA0, 8'h7F, 8'h05, k, r, s, t, a);
        chk(r && s == 2'd3 && a == 7'h7F, "R8 aux no page reg", {r, s, a}, {1'b1, 2'd3, 7'h7F});
        rd_at(8'hA2, 8'h7F, d, r, s, t, a);
        chk(d == 8'h00, "R8 page untouched", 32'(d), 0);
    endtask

    task automatic t_single();
        logic k, r; logic [1:0] s; logic [7:0] t, d; logic [6:0] a;
        cfg_single = 1'b1;
        wr_at(8'hA0, 8'h05, 8'h11, k, r, s, t, a);
        chk(!k, "R2 no ack A0 single", 32'(k), 0);
        chk(!r, "R2 bytes ignored", 32'(r), 0);
        rd_at(8'hA2, 8'h8A, d, r, s, t, a);
        chk(r && s == 2'd3 && a == 7'h0A && d == mem_model(2'd3, 8'h00, 7'h0A), "R6 page 0 aux",
            {r, s, a}, {1'b1, 2'd3, 7'h0A});
        wr_at(8'hA2, 8'h7F, 8'h01, k, r, s, t, a);
        rd_at(8'hA2, 8'h8A, d, r, s, t, a);
        chk(r && s == 2'd3 && a == 7'h0A, "R6 page 1 aliases", {r, s, a}, {1'b1, 2'd3, 7'h0A});
        wr_at(8'hA2, 8'h7F, 8'h00, k, r, s, t, a);
        cfg_single = 1'b0;
    endtask

    task automatic t_fix();
        logic k;
        cfg_main = 8'hC4; cfg_fix = 1'b1;
        do_start(8'hA2, k); do_stop();
        chk(!k, "R1 fixed A2 ignored", 32'(k), 0);
        do_start(8'hC4, k); do_stop();
        chk(k, "R1 programmed ack", 32'(k), 1);
        cfg_fix = 1'b0;
    endtask

    task automatic t_pointer();
        logic r, k; logic [1:0] s; logic [7:0] t, d; logic [6:0] a;
        rd_at(8'hA2, 8'hFF, d, r, s, t, a);
        chk(r && s == 2'd2 || !r, "R9 setup", 0, 0);
        do_start(8'hA3, k);
        rbyte(d, r, s, t, a);
        do_stop();
        chk(r && s == 2'd1 && a == 7'h00, "R9 wrap to 00", {r, s, a}, {1'b1, 2'd1, 7'h00});
        rd_at(8'hA2, 8'h30, d, r, s, t, a);
        do_start(8'hA3, k);
        rbyte(d, r, s, t, a);
        rbyte(d, r, s, t, a);
        do_stop();
        chk(r && a == 7'h32, "R9 sequential", {r, a}, {1'b1, 7'h32});
    endtask

    task automatic t_other();
        logic k, r; logic [1:0] s; logic [7:0] t; logic [6:0] a;
        do_start(8'hB0, k);
        chk(!k, "R11 other no ack", 32'(k), 0);
        wbyte(8'h10, r, s, t, a);
        wbyte(8'h22, r, s, t, a);
        chk(!r, "R11 bytes ignored", 32'(r), 0);
        do_stop();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_main_lower();
        t_tables();
        t_undef();
        t_aux_dual();
        t_single();
        t_fix();
        t_pointer();
        t_other();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule